// File: doc/BRIEF.md
# Transmit Gather DMA Engine

This block builds outgoing packets from several pieces of host memory. Software describes each piece with one request word: a host address, a byte length and a flag that says whether more pieces of the same packet follow. For each accepted request the engine waits until the transmit FIFO can hold the bytes already gathered plus the new piece. It then waits for the shared DMA read port to be free, issues one read of exactly the requested length and models the read time. When the read completes, it appends the piece to a staging packet.

When a piece arrives without the follow-on flag, the whole staged packet is pushed into the transmit FIFO in one step. At the end of every piece the engine publishes a done status with the piece length and a complete bit, and pulses a per-piece interrupt. After a push, the engine raises a FIFO-full interrupt and latches a full flag if the remaining free space is below a software-set threshold. The engine also keeps a count of the bytes held in the FIFO, and the wire-side transmitter reduces that count as it drains packets.

Top module: `tx_gather_dma`

## Requirements
- R1: After reset the engine is idle: `done_busy`=0, `done_complete`=0, `dma_req`=0, `fifo_used`=0, `fifo_free`=FIFO_BYTES, `full_flag`=0 and `dma_buf_off`=0.
- R2: A request write while `done_busy`=0 is accepted. On the next cycle `done_busy`=1 and `done_complete`=0. A request write while `done_busy`=1 is ignored and has no effect on the read that is issued or on the done status.
- R3: An accepted request with `tx_enable`=0 stays pending, with `done_busy`=1 and no read issued. The request proceeds once `tx_enable` goes high.
- R4: No read is issued until `fifo_free` is at least the staged byte count plus the requested length.
- R5: While `dma_busy`=1 no read is issued. A read is a one-cycle `dma_req` pulse that carries the requested address and exact length, with `dma_buf_off` equal to the bytes already staged.
- R6: With FIFO room and a free DMA port, `done_complete` rises exactly 3 + max(1, LAT_DELAY + ceil(len/64)×LAT_FACTOR) clock edges after the edge that accepts the request.
- R7: At the end of every piece, `done_len` holds the piece length, `done_complete`=1, `done_busy`=0, and `irq_dma` pulses for one cycle.
- R8: A piece with `req_more`=1 makes no push. The staged count grows by its length, so the next piece's read reports that total in `dma_buf_off`.
- R9: A piece with `req_more`=0 pushes for one cycle with `push_len` equal to the staged count plus its length. `fifo_used` then grows by that amount and the staged count returns to 0.
- R10: If free space after a push is below `max_copy`, `irq_full` pulses and `full_flag` is set. `full_flag` clears once `fifo_free` is again at least `max_copy`.
- R11: A request whose length plus the staged count exceeds MAX_PKT is rejected. `err_oversize` pulses, `done_busy` stays 0 and the staged bytes are discarded.
- R12: A `drain_valid` cycle lowers `fifo_used` by `drain_len` and raises `fifo_free` by the same amount.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_enable | input | 1 | Transmit enable; gates the start of a pending request |
| max_copy | input | CNT_W | Free-space threshold for the full interrupt |
| req_wr | input | 1 | Request register write strobe |
| req_addr | input | ADDR_W | Host address of the piece |
| req_len | input | LEN_W | Piece length in bytes |
| req_more | input | 1 | More pieces of this packet follow |
| done_busy | output | 1 | A request is outstanding |
| done_complete | output | 1 | Last piece finished |
| done_len | output | LEN_W | Length of the last finished piece |
| dma_busy | input | 1 | Shared DMA read port is occupied |
| dma_req | output | 1 | One-cycle read issue strobe |
| dma_addr | output | ADDR_W | Read address |
| dma_len | output | LEN_W | Read length |
| dma_buf_off | output | STG_W | Staging offset the read lands at |
| push_valid | output | 1 | Whole packet pushed into the FIFO |
| push_len | output | STG_W | Length of the pushed packet |
| drain_valid | input | 1 | Transmitter removed a packet |
| drain_len | input | CNT_W | Bytes removed |
| fifo_used | output | CNT_W | Bytes held in the FIFO |
| fifo_free | output | CNT_W | Free bytes in the FIFO |
| irq_dma | output | 1 | Per-piece completion pulse |
| irq_full | output | 1 | FIFO-full pulse after a push |
| full_flag | output | 1 | Latched FIFO-full condition |
| err_oversize | output | 1 | Oversize request rejected |

## Verification
The checker assumes that `drain_len` never exceeds `fifo_used`, so free space can only grow while a piece waits for room. It also assumes that request lengths are nonzero. The bench drains only bytes it has itself counted as pushed, and uses only positive lengths. With these assumptions, a packet that passed the room check still fits when it is pushed, and the read and push properties hold.

// File: rtl/txg_pkg.sv
`timescale 1ns/1ps
package txg_pkg;

  typedef enum logic [2:0] {
    TXG_IDLE,
    TXG_WAIT,
    TXG_BEGIN,
    TXG_COPY,
    TXG_DONE
  } txg_state_e;

  localparam int unsigned TXG_CHUNK_SHIFT = 6;

  // cycles a read occupies: fixed part plus a cost per started 64-byte chunk
  function automatic int unsigned txg_read_cycles(input int unsigned len,
                                                  input int unsigned dly,
                                                  input int unsigned fac);
    int unsigned chunks;
    int unsigned total;
    chunks = (len + (32'd1 << TXG_CHUNK_SHIFT) - 32'd1) >> TXG_CHUNK_SHIFT;
    total  = dly + chunks * fac;
    if (total == 0) total = 1;
    return total;
  endfunction

  // room test: free bytes must cover the staged bytes plus the new piece
  function automatic logic txg_fits(input int unsigned free_b,
                                    input int unsigned staged_b,
                                    input int unsigned frag_b);
    return free_b >= staged_b + frag_b;
  endfunction

endpackage

// File: rtl/txg_fifo_acct.sv
`timescale 1ns/1ps
module txg_fifo_acct #(
  parameter int unsigned FIFO_BYTES = 32768,
  parameter int CNT_W = 16,
  parameter int STG_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [STG_W-1:0] push_len,
  input  logic             drain,
  input  logic [CNT_W-1:0] drain_len,
  output logic [CNT_W-1:0] used,
  output logic [CNT_W-1:0] free
);
  logic [CNT_W-1:0] used_q;
  logic [CNT_W-1:0] add_b;
  logic [CNT_W-1:0] sub_b;

  assign add_b = push  ? CNT_W'(push_len) : '0;
  assign sub_b = drain ? drain_len        : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) used_q <= '0;
    else        used_q <= used_q + add_b - sub_b;
  end

  assign used = used_q;
  assign free = CNT_W'(FIFO_BYTES) - used_q;
endmodule

// File: rtl/txg_stage.sv
`timescale 1ns/1ps
module txg_stage #(
  parameter int LEN_W = 15,
  parameter int STG_W = 15,
  parameter int unsigned MAX_PKT = 16384
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_try,
  input  logic [LEN_W-1:0] req_len,
  input  logic             frag_done,
  input  logic             frag_more,
  input  logic [LEN_W-1:0] frag_len,
  output logic [STG_W-1:0] staged,
  output logic [STG_W-1:0] pkt_len,
  output logic             reject,
  output logic             err_pulse
);
  localparam int SUM_W = ((STG_W > LEN_W) ? STG_W : LEN_W) + 1;

  logic [STG_W-1:0] staged_q;
  logic             err_q;
  logic [SUM_W-1:0] req_sum;
  logic [SUM_W-1:0] frag_sum;

  assign req_sum  = SUM_W'(staged_q) + SUM_W'(req_len);
  assign frag_sum = SUM_W'(staged_q) + SUM_W'(frag_len);
  assign reject   = req_try && (req_sum > SUM_W'(MAX_PKT));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      staged_q <= '0;
      err_q    <= 1'b0;
    end else begin
      err_q <= reject;
      if (reject)
        staged_q <= '0;
      else if (frag_done)
        staged_q <= frag_more ? STG_W'(frag_sum) : '0;
    end
  end

  assign staged    = staged_q;
  assign pkt_len   = STG_W'(frag_sum);
  assign err_pulse = err_q;
endmodule

// File: rtl/txg_seq.sv
`timescale 1ns/1ps
module txg_seq
  import txg_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 15,
  parameter int CNT_W = 16,
  parameter int STG_W = 15,
  parameter int LAT_W = 16,
  parameter int unsigned LAT_DELAY = 4,
  parameter int unsigned LAT_FACTOR = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_enable,
  input  logic              req_take,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_more,
  input  logic [CNT_W-1:0]  fifo_free,
  input  logic [STG_W-1:0]  staged,
  input  logic              dma_busy,
  output logic              dma_req,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [LEN_W-1:0]  dma_len,
  output logic              frag_done,
  output logic              frag_more,
  output logic [LEN_W-1:0]  frag_len,
  output logic              busy,
  output logic              done_complete,
  output logic [LEN_W-1:0]  done_len
);
  txg_state_e        state_q;
  logic              pend_q;
  logic [ADDR_W-1:0] addr_q;
  logic [LEN_W-1:0]  len_q;
  logic              more_q;
  logic [LAT_W-1:0]  lat_q;
  logic              cmpl_q;
  logic [LEN_W-1:0]  dlen_q;
  logic              room_ok;
  logic [LAT_W-1:0]  lat_load;

  assign room_ok  = txg_fits(32'(fifo_free), 32'(staged), 32'(len_q));
  assign lat_load = LAT_W'(txg_read_cycles(32'(len_q), LAT_DELAY, LAT_FACTOR));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= TXG_IDLE;
      pend_q  <= 1'b0;
      addr_q  <= '0;
      len_q   <= '0;
      more_q  <= 1'b0;
      lat_q   <= '0;
      cmpl_q  <= 1'b0;
      dlen_q  <= '0;
    end else begin
      case (state_q)
        TXG_IDLE: begin
          if (req_take) begin
            addr_q <= req_addr;
            len_q  <= req_len;
            more_q <= req_more;
            cmpl_q <= 1'b0;
            dlen_q <= '0;
            if (tx_enable) state_q <= TXG_WAIT;
            else           pend_q  <= 1'b1;
          end else if (pend_q && tx_enable) begin
            pend_q  <= 1'b0;
            state_q <= TXG_WAIT;
          end
        end
        TXG_WAIT: begin
          if (room_ok) state_q <= TXG_BEGIN;
        end
        TXG_BEGIN: begin
          if (!dma_busy) begin
            lat_q   <= lat_load;
            state_q <= TXG_COPY;
          end
        end
        TXG_COPY: begin
          if (lat_q <= LAT_W'(1)) state_q <= TXG_DONE;
          else                    lat_q   <= lat_q - LAT_W'(1);
        end
        TXG_DONE: begin
          cmpl_q  <= 1'b1;
          dlen_q  <= len_q;
          state_q <= TXG_IDLE;
        end
        default: state_q <= TXG_IDLE;
      endcase
    end
  end

  assign dma_req       = (state_q == TXG_BEGIN) && !dma_busy;
  assign dma_addr      = addr_q;
  assign dma_len       = len_q;
  assign frag_done     = (state_q == TXG_DONE);
  assign frag_more     = more_q;
  assign frag_len      = len_q;
  assign busy          = (state_q != TXG_IDLE) || pend_q;
  assign done_complete = cmpl_q;
  assign done_len      = dlen_q;
endmodule

// File: rtl/tx_gather_dma.sv
`timescale 1ns/1ps
module tx_gather_dma #(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 15,
  parameter int unsigned FIFO_BYTES = 32768,
  parameter int unsigned MAX_PKT = 16384,
  parameter int unsigned LAT_DELAY = 4,
  parameter int unsigned LAT_FACTOR = 2,
  parameter int LAT_W = 16,
  localparam int CNT_W = $clog2(FIFO_BYTES + 1),
  localparam int STG_W = $clog2(MAX_PKT + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_enable,
  input  logic [CNT_W-1:0]  max_copy,
  input  logic              req_wr,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              req_more,
  output logic              done_busy,
  output logic              done_complete,
  output logic [LEN_W-1:0]  done_len,
  input  logic              dma_busy,
  output logic              dma_req,
  output logic [ADDR_W-1:0] dma_addr,
  output logic [LEN_W-1:0]  dma_len,
  output logic [STG_W-1:0]  dma_buf_off,
  output logic              push_valid,
  output logic [STG_W-1:0]  push_len,
  input  logic              drain_valid,
  input  logic [CNT_W-1:0]  drain_len,
  output logic [CNT_W-1:0]  fifo_used,
  output logic [CNT_W-1:0]  fifo_free,
  output logic              irq_dma,
  output logic              irq_full,
  output logic              full_flag,
  output logic              err_oversize
);
  // named internal events
  logic             ev_req_try;
  logic             ev_reject;
  logic             ev_req_take;
  logic             ev_frag_done;
  logic             ev_push;
  logic             ev_full_hit;
  logic             frag_more;
  logic [LEN_W-1:0] frag_len;
  logic [STG_W-1:0] stg_len;
  logic [STG_W-1:0] pkt_len;
  logic [CNT_W-1:0] free_after;
  logic             irq_dma_q;
  logic             irq_full_q;
  logic             full_q;

  assign ev_req_try  = req_wr && !done_busy;
  assign ev_req_take = ev_req_try && !ev_reject;

  txg_stage #(.LEN_W(LEN_W), .STG_W(STG_W), .MAX_PKT(MAX_PKT)) u_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_try   (ev_req_try),
    .req_len   (req_len),
    .frag_done (ev_frag_done),
    .frag_more (frag_more),
    .frag_len  (frag_len),
    .staged    (stg_len),
    .pkt_len   (pkt_len),
    .reject    (ev_reject),
    .err_pulse (err_oversize)
  );

  txg_seq #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .STG_W(STG_W),
    .LAT_W(LAT_W), .LAT_DELAY(LAT_DELAY), .LAT_FACTOR(LAT_FACTOR)
  ) u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .tx_enable     (tx_enable),
    .req_take      (ev_req_take),
    .req_addr      (req_addr),
    .req_len       (req_len),
    .req_more      (req_more),
    .fifo_free     (fifo_free),
    .staged        (stg_len),
    .dma_busy      (dma_busy),
    .dma_req       (dma_req),
    .dma_addr      (dma_addr),
    .dma_len       (dma_len),
    .frag_done     (ev_frag_done),
    .frag_more     (frag_more),
    .frag_len      (frag_len),
    .busy          (done_busy),
    .done_complete (done_complete),
    .done_len      (done_len)
  );

  assign ev_push = ev_frag_done && !frag_more;

  txg_fifo_acct #(.FIFO_BYTES(FIFO_BYTES), .CNT_W(CNT_W), .STG_W(STG_W)) u_acct (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (ev_push),
    .push_len  (pkt_len),
    .drain     (drain_valid),
    .drain_len (drain_len),
    .used      (fifo_used),
    .free      (fifo_free)
  );

  assign free_after  = fifo_free - CNT_W'(pkt_len);
  assign ev_full_hit = ev_push && (free_after < max_copy);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_dma_q  <= 1'b0;
      irq_full_q <= 1'b0;
      full_q     <= 1'b0;
    end else begin
      irq_dma_q  <= ev_frag_done;
      irq_full_q <= ev_full_hit;
      if (ev_full_hit)              full_q <= 1'b1;
      else if (fifo_free >= max_copy) full_q <= 1'b0;
    end
  end

  assign dma_buf_off = stg_len;
  assign push_valid  = ev_push;
  assign push_len    = pkt_len;
  assign irq_dma     = irq_dma_q;
  assign irq_full    = irq_full_q;
  assign full_flag   = full_q;
endmodule

// File: rtl/tx_gather_dma_chk.sv
`timescale 1ns/1ps
module tx_gather_dma_chk #(
  parameter int ADDR_W = 32,
  parameter int LEN_W = 15,
  parameter int CNT_W = 16,
  parameter int STG_W = 15
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dma_req,
  input logic [LEN_W-1:0] dma_len,
  input logic [STG_W-1:0] dma_buf_off,
  input logic [CNT_W-1:0] fifo_free,
  input logic             push_valid,
  input logic [STG_W-1:0] push_len,
  input logic             irq_dma,
  input logic             irq_full,
  input logic             full_flag,
  input logic             done_busy,
  input logic             done_complete,
  input logic             err_oversize
);
  AST_ROOM_BEFORE_READ: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |-> (32'(fifo_free) >= 32'(dma_buf_off) + 32'(dma_len))); // R4
  AST_READ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req |=> !dma_req); // R5
  AST_PIECE_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    irq_dma |=> !irq_dma); // R7
  AST_PIECE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_dma |-> (done_complete && !done_busy)); // R7
  AST_PUSH_FITS: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid |-> (32'(push_len) <= 32'(fifo_free))); // R9
  AST_FULL_LATCHED: assert property (@(posedge clk) disable iff (!rst_n)
    irq_full |-> full_flag); // R10
  AST_REJECT_LEAVES_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_oversize |-> !done_busy); // R11
endmodule

bind tx_gather_dma tx_gather_dma_chk #(
  .ADDR_W(ADDR_W), .LEN_W(LEN_W), .CNT_W(CNT_W), .STG_W(STG_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .dma_req       (dma_req),
  .dma_len       (dma_len),
  .dma_buf_off   (dma_buf_off),
  .fifo_free     (fifo_free),
  .push_valid    (push_valid),
  .push_len      (push_len),
  .irq_dma       (irq_dma),
  .irq_full      (irq_full),
  .full_flag     (full_flag),
  .done_busy     (done_busy),
  .done_complete (done_complete),
  .err_oversize  (err_oversize)
);

// File: tb/tb_tx_gather_dma.sv
`timescale 1ns/1ps
module tb_tx_gather_dma;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 15;
  localparam int FIFO_B = 8192;
  localparam int CNT_W  = $clog2(FIFO_B + 1);
  localparam int STG_W  = $clog2(16384 + 1);
  localparam int NV     = 5;
  localparam int V_LEN  [NV] = '{100, 64, 65, 1, 200};
  localparam bit V_MORE [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_enable = 1'b1;
  logic [CNT_W-1:0] max_copy = CNT_W'(1500);
  logic req_wr = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic req_more = 1'b0;
  logic done_busy, done_complete;
  logic [LEN_W-1:0] done_len;
  logic dma_busy = 1'b0;
  logic dma_req;
  logic [ADDR_W-1:0] dma_addr;
  logic [LEN_W-1:0] dma_len;
  logic [STG_W-1:0] dma_buf_off;
  logic push_valid;
  logic [STG_W-1:0] push_len;
  logic drain_valid = 1'b0;
  logic [CNT_W-1:0] drain_len = '0;
  logic [CNT_W-1:0] fifo_used, fifo_free;
  logic irq_dma, irq_full, full_flag, err_oversize;

  always #4 clk = ~clk;

  tx_gather_dma #(.FIFO_BYTES(FIFO_B)) dut (.*);

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int n_req = 0, n_push = 0, n_idma = 0, n_ifull = 0, n_err = 0;
  int last_addr = 0, last_len = 0, last_off = 0, last_push = 0;

  always @(negedge clk) begin
    if (dma_req) begin
      n_req++; last_addr = int'(dma_addr); last_len = int'(dma_len); last_off = int'(dma_buf_off);
    end
    if (push_valid) begin n_push++; last_push = int'(push_len); end
    if (irq_dma) n_idma++;
    if (irq_full) n_ifull++;
    if (err_oversize) n_err++;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog (all requirements) act=%0d exp<150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_lat(input int len);
    int c;
    c = 4 + 2 * ((len + 63) / 64);
    return (c < 1) ? 1 : c;
  endfunction

  task automatic write_req(input int addr, input int len, input bit more);
    @(negedge clk);
    req_wr = 1'b1; req_addr = ADDR_W'(addr); req_len = LEN_W'(len); req_more = more;
    @(negedge clk);
    req_wr = 1'b0;
    #1;
  endtask

  task automatic wait_done(output int n);
    n = -1;
    for (int k = 1; k < 4000; k++) begin
      @(posedge clk); #1;
      if (done_complete) begin n = k; break; end
    end
  endtask

  task automatic drain(input int bytes);
    @(negedge clk);
    drain_valid = 1'b1; drain_len = CNT_W'(bytes);
    @(negedge clk);
    drain_valid = 1'b0;
    #1;
  endtask

  task automatic timed_frag(input int addr, input int len, input bit more, output int n);
    @(negedge clk);
    req_wr = 1'b1; req_addr = ADDR_W'(addr); req_len = LEN_W'(len); req_more = more;
    @(posedge clk); #1;
    req_wr = 1'b0;
    n = -1;
    for (int k = 1; k < 4000; k++) begin
      @(posedge clk); #1;
      if (done_complete) begin n = k; break; end
    end
  endtask

  initial begin
    int n, stage, used, p0, i0, r0, f0, e0;
    stage = 0; used = 0;
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    chk(done_busy == 0 && done_complete == 0 && dma_req == 0, "R1 idle", int'(done_busy), 0);
    chk(fifo_used == 0, "R1 used", int'(fifo_used), 0);
    chk(int'(fifo_free) == FIFO_B && full_flag == 0 && dma_buf_off == 0, "R1 free", int'(fifo_free), FIFO_B);
    @(negedge clk); rst_n = 1'b1;

    // table walk: R5 R6 R7 R8 R9
    for (int v = 0; v < NV; v++) begin
      int a;
      a = 32'h1000 + v * 32'h100;
      p0 = n_push; i0 = n_idma;
      timed_frag(a, V_LEN[v], V_MORE[v], n);
      @(negedge clk); #1;
      chk(n == 3 + exp_lat(V_LEN[v]), "R6 latency", n, 3 + exp_lat(V_LEN[v]));
      chk(int'(done_len) == V_LEN[v] && done_busy == 0, "R7 done_len", int'(done_len), V_LEN[v]);
      chk(n_idma == i0 + 1, "R7 irq_dma", n_idma, i0 + 1);
      chk(last_addr == a && last_len == V_LEN[v], "R5 read addr/len", last_len, V_LEN[v]);
      chk(last_off == stage, "R8 staging offset", last_off, stage);
      if (V_MORE[v]) begin
        chk(n_push == p0, "R8 no push", n_push, p0);
        stage += V_LEN[v];
      end else begin
        used += stage + V_LEN[v];
        chk(n_push == p0 + 1 && last_push == stage + V_LEN[v], "R9 push_len", last_push, stage + V_LEN[v]);
        chk(int'(fifo_used) == used, "R9 used", int'(fifo_used), used);
        stage = 0;
      end
    end
    chk(n_ifull == 0 && full_flag == 0, "R10 no full", n_ifull, 0);

    // R2 / R5: dma port busy, second write ignored
    dma_busy = 1'b1;
    r0 = n_req;
    write_req(32'h2000, 300, 1'b0);
    chk(done_busy == 1 && done_complete == 0, "R2 busy set", int'(done_busy), 1);
    write_req(32'h3000, 500, 1'b0);
    repeat (10) @(posedge clk);
    #1;
    chk(n_req == r0, "R5 held while dma busy", n_req, r0);
    dma_busy = 1'b0;
    wait_done(n);
    @(negedge clk); #1;
    chk(int'(done_len) == 300, "R2 second write ignored", int'(done_len), 300);
    chk(last_len == 300 && last_addr == 32'h2000, "R2 read from first", last_len, 300);
    used += 300;

    // R3 transmit disabled
    tx_enable = 1'b0;
    r0 = n_req;
    write_req(32'h4000, 50, 1'b0);
    repeat (20) @(posedge clk);
    #1;
    chk(n_req == r0 && done_busy == 1 && done_complete == 0, "R3 pending", n_req, r0);
    tx_enable = 1'b1;
    wait_done(n);
    chk(n > 0 && int'(done_len) == 50, "R3 resumes", int'(done_len), 50);
    used += 50;
    @(negedge clk); #1;

    // R12 drain
    drain(used);
    chk(fifo_used == 0 && int'(fifo_free) == FIFO_B, "R12 drain", int'(fifo_used), 0);
    used = 0;

    // R10 full and R4 room wait
    f0 = n_ifull;
    write_req(32'h5000, 7000, 1'b0);
    wait_done(n);
    @(negedge clk); #1;
    chk(n_ifull == f0 + 1 && full_flag == 1, "R10 full raised", n_ifull, f0 + 1);
    chk(int'(fifo_used) == 7000, "R9 used 7000", int'(fifo_used), 7000);
    r0 = n_req;
    write_req(32'h6000, 2000, 1'b0);
    repeat (30) @(posedge clk);
    #1;
    chk(n_req == r0 && done_complete == 0, "R4 waits for room", n_req, r0);
    drain(7000);
    @(posedge clk); #1;
    chk(full_flag == 0, "R10 full cleared", int'(full_flag), 0);
    wait_done(n);
    @(negedge clk); #1;
    chk(n > 0 && int'(fifo_used) == 2000, "R4 proceeds", int'(fifo_used), 2000);
    drain(2000);

    // R11 oversize rejection
    write_req(32'h7000, 8000, 1'b1);
    wait_done(n);
    @(negedge clk); #1;
    e0 = n_err; p0 = n_push;
    write_req(32'h8000, 9000, 1'b0);
    chk(n_err == e0 + 1, "R11 err pulse", n_err, e0 + 1);
    chk(done_busy == 0, "R11 not busy", int'(done_busy), 0);
    write_req(32'h9000, 100, 1'b0);
    wait_done(n);
    @(negedge clk); #1;
    chk(last_off == 0 && n_push == p0 + 1 && last_push == 100, "R11 staging discarded", last_push, 100);

    summary();
    $finish;
  end
endmodule